// File: doc/BRIEF.md
# I2C Slave Status Engine

This block is the target side of an I2C bus. It watches the open-drain clock and data lines and pulls data low only when it must send a bit. It recognises one programmable 7-bit address and the general call address (00h). It receives bytes into a data register and sends bytes from that register. Whether it acknowledges a byte depends on an acknowledge-enable bit that software controls.

After every bus event it loads an 8-bit status code and raises a flag. That flag also drives the interrupt output. While the flag is set, the block holds the clock line low, so the bus master waits until software has read the status, serviced the data register and cleared the flag.

Software uses a four-entry register port with a single-cycle write strobe and a combinational read. Master operation, arbitration, 10-bit addresses and clock generation are not part of this block.

Top module: `i2c_status_slave`

## Requirements
- R1: Register map. Offset 0 holds the own address in bits 7:1. Offset 1 is the data register. Offset 2 is control: bit 2 is acknowledge enable; bit 3 reads 1 while the flag is set, and writing 0 to it clears the flag; writing 1 to bit 4 aborts to idle and clears the flag. Offset 3 is status. After reset, acknowledge enable and the flag are 0, and neither line is driven.
- R2: Each status code and the flag are loaded at the SCL falling edge that ends the acknowledge bit. While the flag is set, the block holds SCL low. Clearing the flag releases SCL.
- R3: The general call address 00h, when acknowledged, gives status 70h.
- R4: Its own address with the write bit, when acknowledged, gives status 60h. Each following byte goes into the data register. The status is 80h if that byte was acknowledged and 88h if it was not.
- R5: A byte received after a general call gives 90h if acknowledged and 98h if not.
- R6: With acknowledge enable at 0, a received byte is answered with NACK. After that the block is unaddressed: further bytes get no acknowledge, raise no flag and leave the data register alone, and a STOP raises no event.
- R7: A STOP received while addressed, at the start of a byte, gives status A0h.
- R8: Its own address with the read bit, when acknowledged, gives status A8h. The data register is then sent MSB first.
- R9: In transmit, an acknowledge from the master gives B8h. If acknowledge enable is 0 at that point, the byte counts as the last one: the status is C8h and the block goes unaddressed. A NACK from the master gives C0h.
- R10: Any other address byte is not acknowledged and leaves the flag at 0.
- R11: A START or STOP seen inside a byte transfer is a bus error. It gives status 00h, sets the flag and releases SDA. The abort bit clears the flag, returns the block to idle, and drives no STOP.
- R12: Status reads F8h whenever the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_hold_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | Pull SDA low |
| irq_o | output | 1 | Event flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
The bench uses the default parameters: two synchroniser stages per line and two reset stages. Each bus half-period lasts twenty system clocks, well above the roughly four-cycle path from a line edge to a registered decision. That margin lets acknowledge bits and transmit data settle before the modelled master samples them, and it makes stretch, release and mid-byte START/STOP timing directly observable at the pins. The bench models open-drain wiring, so every code path runs against its own driven lines: ACK, NACK, last-byte, unaddressed and bus-error paths.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int IDX_W  = $clog2(BYTE_W);

  localparam logic [7:0] SC_BUS_ERR    = 8'h00;
  localparam logic [7:0] SC_OWN_WR     = 8'h60;
  localparam logic [7:0] SC_GCALL      = 8'h70;
  localparam logic [7:0] SC_RX_ACK     = 8'h80;
  localparam logic [7:0] SC_RX_NACK    = 8'h88;
  localparam logic [7:0] SC_GC_RX_ACK  = 8'h90;
  localparam logic [7:0] SC_GC_RX_NACK = 8'h98;
  localparam logic [7:0] SC_END_COND   = 8'hA0;
  localparam logic [7:0] SC_OWN_RD     = 8'hA8;
  localparam logic [7:0] SC_TX_ACK     = 8'hB8;
  localparam logic [7:0] SC_TX_NACK    = 8'hC0;
  localparam logic [7:0] SC_TX_LAST    = 8'hC8;
  localparam logic [7:0] SC_IDLE       = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_ERR
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  assign start_o = scl_lvl_i & sda_fall_i;
  assign stop_o  = scl_lvl_i & sda_rise_i;
endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2c_ss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [6:0]        own_addr_i,
  input  logic              ack_en_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              abort_i,
  output logic              sda_low_o,
  output logic              ev_valid_o,
  output logic [7:0]        ev_code_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(BYTE_W - 1);

  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              gc_q, gc_d, rd_q, rd_d, ack_q, ack_d;
  logic              hit_own, hit_gc;

  assign hit_own = (shift_q[BYTE_W-1:1] == own_addr_i);
  assign hit_gc  = (shift_q == '0);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    shift_d    = shift_q;
    gc_d       = gc_q;
    rd_d       = rd_q;
    ack_d      = ack_q;
    ev_valid_o = 1'b0;
    ev_code_o  = SC_IDLE;
    rx_valid_o = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (start_i || stop_i) begin
      cnt_d = '0;
      case (state_q)
        ST_IDLE, ST_ADDR: state_d = start_i ? ST_ADDR : ST_IDLE;
        ST_ERR:           state_d = ST_ERR;
        ST_RX: begin
          ev_valid_o = 1'b1;
          if (cnt_q <= CNT_W'(1)) begin
            ev_code_o = SC_END_COND;
            state_d   = start_i ? ST_ADDR : ST_IDLE;
          end else begin
            ev_code_o = SC_BUS_ERR;
            state_d   = ST_ERR;
          end
        end
        default: begin
          ev_valid_o = 1'b1;
          ev_code_o  = SC_BUS_ERR;
          state_d    = ST_ERR;
        end
      endcase
    end else begin
      case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i && cnt_q < FULL_CNT) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_i};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == FULL_CNT) begin
            cnt_d = '0;
            if (state_q == ST_RX) begin
              rx_valid_o = 1'b1;
              ack_d      = ack_en_i;
              state_d    = ST_RX_ACK;
            end else if (ack_en_i && (hit_own || hit_gc)) begin
              gc_d    = hit_gc;
              rd_d    = shift_q[0] & ~hit_gc;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          ev_valid_o = 1'b1;
          ev_code_o  = gc_q ? SC_GCALL : (rd_q ? SC_OWN_RD : SC_OWN_WR);
          state_d    = rd_q ? ST_TX : ST_RX;
          cnt_d      = '0;
        end
        ST_RX_ACK: if (scl_fall_i) begin
          ev_valid_o = 1'b1;
          if (gc_q) ev_code_o = ack_q ? SC_GC_RX_ACK : SC_GC_RX_NACK;
          else      ev_code_o = ack_q ? SC_RX_ACK : SC_RX_NACK;
          state_d = ack_q ? ST_RX : ST_IDLE;
          cnt_d   = '0;
        end
        ST_TX: if (scl_fall_i) begin
          if (cnt_q == LAST_TX) begin
            state_d = ST_TX_ACK;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) ack_d = ~sda_i;
          else if (scl_fall_i) begin
            ev_valid_o = 1'b1;
            ev_code_o  = !ack_q ? SC_TX_NACK : (ack_en_i ? SC_TX_ACK : SC_TX_LAST);
            state_d    = (ack_q && ack_en_i) ? ST_TX : ST_IDLE;
            cnt_d      = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      gc_q    <= 1'b0;
      rd_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      gc_q    <= gc_d;
      rd_q    <= rd_d;
      ack_q   <= ack_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_ADDR_ACK: sda_low_o = 1'b1;
      ST_RX_ACK:   sda_low_o = ack_q;
      ST_TX:       sda_low_o = ~tx_byte_i[TOP_IDX - cnt_q[IDX_W-1:0]];
      default:     sda_low_o = 1'b0;
    endcase
  end

  assign rx_byte_o = shift_q;

  // R2
  ev_on_bus_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> (scl_fall_i || start_i || stop_i));
  // R11
  err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_code_o == SC_BUS_ERR) |=> !sda_low_o);
  // R6
  nack_unaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && (ev_code_o == SC_RX_NACK || ev_code_o == SC_GC_RX_NACK))
      |=> state_q == ST_IDLE);
  // R9
  last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid_o && ev_code_o == SC_TX_LAST) |=> !sda_low_o);
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave
  import i2c_ss_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_hold_low_o,
  output logic       sda_drive_low_o,
  output logic       irq_o,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  localparam int LINES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  logic [LINES-1:0] line_in, line_lvl, line_rise, line_fall;
  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_int_n), .line_i(line_in[g]),
      .level_o(line_lvl[g]), .rise_o(line_rise[g]), .fall_o(line_fall[g]));
  end

  logic start_c, stop_c;
  i2c_cond_detect u_cond (
    .scl_lvl_i(line_lvl[0]), .sda_rise_i(line_rise[1]), .sda_fall_i(line_fall[1]),
    .start_o(start_c), .stop_o(stop_c));

  logic [6:0]        own_q, own_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              ack_en_q, ack_en_d, iflg_q, iflg_d;
  logic [7:0]        status_q, status_d;
  logic              wr_own, wr_data, wr_ctl, abort;
  logic              ev_valid, rx_valid, sda_low;
  logic [7:0]        ev_code;
  logic [BYTE_W-1:0] rx_byte;

  assign wr_own  = reg_wr_i && reg_addr_i == 2'd0;
  assign wr_data = reg_wr_i && reg_addr_i == 2'd1;
  assign wr_ctl  = reg_wr_i && reg_addr_i == 2'd2;
  assign abort   = wr_ctl && reg_wdata_i[4];

  i2c_slave_core u_core (
    .clk(clk), .rst_n(rst_int_n),
    .scl_rise_i(line_rise[0]), .scl_fall_i(line_fall[0]),
    .start_i(start_c), .stop_i(stop_c), .sda_i(line_lvl[1]),
    .own_addr_i(own_q), .ack_en_i(ack_en_q), .tx_byte_i(data_q), .abort_i(abort),
    .sda_low_o(sda_low), .ev_valid_o(ev_valid), .ev_code_o(ev_code),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte));

  always_comb begin
    own_d    = wr_own ? reg_wdata_i[7:1] : own_q;
    data_d   = rx_valid ? rx_byte : (wr_data ? reg_wdata_i : data_q);
    ack_en_d = wr_ctl ? reg_wdata_i[2] : ack_en_q;
    status_d = ev_valid ? ev_code : status_q;
    if (ev_valid)                                    iflg_d = 1'b1;
    else if (wr_ctl && (!reg_wdata_i[3] || abort))   iflg_d = 1'b0;
    else                                             iflg_d = iflg_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      own_q    <= '0;
      data_q   <= '0;
      ack_en_q <= 1'b0;
      iflg_q   <= 1'b0;
      status_q <= SC_IDLE;
    end else begin
      own_q    <= own_d;
      data_q   <= data_d;
      ack_en_q <= ack_en_d;
      iflg_q   <= iflg_d;
      status_q <= status_d;
    end
  end

  always_comb begin
    case (reg_addr_i)
      2'd0:    reg_rdata_o = {own_q, 1'b0};
      2'd1:    reg_rdata_o = data_q;
      2'd2:    reg_rdata_o = {4'b0000, iflg_q, ack_en_q, 2'b00};
      default: reg_rdata_o = iflg_q ? status_q : SC_IDLE;
    endcase
  end

  assign scl_hold_low_o  = iflg_q;
  assign irq_o           = iflg_q;
  assign sda_drive_low_o = sda_low;

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (iflg_q && !wr_ctl) |=> iflg_q);
endmodule

// File: tb/i2c_status_slave_tb.sv
module i2c_status_slave_tb_top;
  localparam int HALF = 20;
  localparam int NVEC = 5;
  // {address byte, data byte, ack enable, status after address, status after data}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h84, 8'h11, 8'h01, 8'h60, 8'h80},
    {8'h84, 8'h22, 8'h00, 8'h60, 8'h88},
    {8'h00, 8'h33, 8'h01, 8'h70, 8'h90},
    {8'h00, 8'h44, 8'h00, 8'h70, 8'h98},
    {8'h90, 8'h55, 8'h01, 8'hF8, 8'hF8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_hold, sda_low, irq;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic scl_bus, sda_bus;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign scl_bus = m_scl & ~scl_hold;
  assign sda_bus = m_sda & ~sda_low;

  i2c_status_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_hold_low_o(scl_hold), .sda_drive_low_o(sda_low), .irq_o(irq),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    wait_clk(2);
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    @(negedge clk);
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(HALF); scl_high(); wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(HALF); scl_high(); wait_clk(HALF);
    m_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wait_clk(HALF); scl_high(); wait_clk(HALF);
    m_scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wait_clk(HALF); scl_high(); wait_clk(HALF / 2);
    b = sda_bus; wait_clk(HALF / 2);
    m_scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic ak;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    cpu_read(2'd3, r); check("R1 status after reset", r, 8'hF8);
    cpu_read(2'd2, r); check("R1 control after reset", r, 8'h00);
    check("R1 no drive after reset", {6'd0, scl_hold, sda_low}, 8'h00);
    cpu_write(2'd0, 8'h84);
    cpu_read(2'd0, r); check("R1 own address readback", r, 8'h84);
    cpu_write(2'd2, 8'h0C);
    cpu_read(2'd2, r); check("R1 ack enable set, flag untouched", r, 8'h04);

    // vector table: write transactions
    for (int v = 0; v < NVEC; v++) begin
      logic [39:0] e;
      e = VEC[v];
      bus_start();
      write_byte(e[39:32], ak);
      check("R10 R3 R4 address acknowledge", {7'd0, ak}, {7'd0, e[15:8] != 8'hF8});
      cpu_read(2'd3, r); check("R3 R4 R10 status after address", r, e[15:8]);
      check("R2 flag follows address event", {7'd0, irq}, {7'd0, e[15:8] != 8'hF8});
      if (ak) begin
        cpu_write(2'd2, e[16] ? 8'h04 : 8'h00);
        write_byte(e[31:24], ak);
        check("R4 R5 R6 data acknowledge", {7'd0, ak}, {7'd0, e[16]});
        cpu_read(2'd3, r); check("R4 R5 status after data", r, e[7:0]);
        cpu_read(2'd1, r); check("R4 received byte", r, e[31:24]);
        cpu_write(2'd2, 8'h04);
        cpu_read(2'd3, r); check("R12 status idle after clear", r, 8'hF8);
        bus_stop();
        wait_clk(4);
        cpu_read(2'd3, r);
        check("R7 R6 status after stop", r, e[16] ? 8'hA0 : 8'hF8);
        cpu_write(2'd2, 8'h04);
      end else begin
        bus_stop();
        wait_clk(4);
        check("R10 no flag for foreign address", {7'd0, irq}, 8'h00);
      end
    end

    // R8 R9 read with ACK then last byte
    bus_start();
    write_byte(8'h85, ak);
    check("R8 read address acked", {7'd0, ak}, 8'h01);
    cpu_read(2'd3, r); check("R8 status own read", r, 8'hA8);
    check("R2 SCL held while flag set", {7'd0, scl_hold}, 8'h01);
    cpu_write(2'd1, 8'hA5);
    cpu_write(2'd2, 8'h04);
    check("R2 SCL released after clear", {7'd0, scl_hold}, 8'h00);
    read_byte(r, 1'b1); check("R8 transmitted byte", r, 8'hA5);
    cpu_read(2'd3, r); check("R9 status master ack", r, 8'hB8);
    cpu_write(2'd1, 8'h3C);
    cpu_write(2'd2, 8'h00);
    read_byte(r, 1'b1); check("R8 second transmitted byte", r, 8'h3C);
    cpu_read(2'd3, r); check("R9 status last byte", r, 8'hC8);
    check("R9 SDA released after last", {7'd0, sda_low}, 8'h00);
    cpu_write(2'd2, 8'h04);
    bus_stop();
    wait_clk(4);
    check("R9 unaddressed after last byte", {7'd0, irq}, 8'h00);

    // R9 master NACK
    bus_start();
    write_byte(8'h85, ak);
    cpu_write(2'd1, 8'h96);
    cpu_write(2'd2, 8'h04);
    read_byte(r, 1'b0); check("R8 byte before nack", r, 8'h96);
    cpu_read(2'd3, r); check("R9 status master nack", r, 8'hC0);
    cpu_write(2'd2, 8'h04);
    bus_stop();
    wait_clk(4);
    check("R9 no event after nack stop", {7'd0, irq}, 8'h00);

    // R6 unaddressed after own NACK
    bus_start();
    write_byte(8'h84, ak);
    cpu_write(2'd2, 8'h00);
    write_byte(8'h12, ak);
    check("R6 nack with enable off", {7'd0, ak}, 8'h00);
    cpu_read(2'd3, r); check("R6 status nack", r, 8'h88);
    cpu_write(2'd2, 8'h04);
    write_byte(8'h34, ak);
    check("R6 later byte not acked", {7'd0, ak}, 8'h00);
    check("R6 later byte raises no flag", {7'd0, irq}, 8'h00);
    cpu_read(2'd1, r); check("R6 data register untouched", r, 8'h12);
    bus_stop();
    wait_clk(4);
    check("R6 stop gives no event", {7'd0, irq}, 8'h00);

    // R11 bus error mid-byte and abort recovery
    bus_start();
    write_byte(8'h84, ak);
    cpu_write(2'd2, 8'h04);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    wait_clk(4);
    cpu_read(2'd3, r); check("R11 bus error status", r, 8'h00);
    check("R11 flag set on error", {7'd0, irq}, 8'h01);
    check("R11 SDA released on error", {7'd0, sda_low}, 8'h00);
    cpu_write(2'd2, 8'h14);
    cpu_read(2'd3, r); check("R11 R12 status after abort", r, 8'hF8);
    check("R11 flag cleared by abort", {7'd0, irq}, 8'h00);
    bus_start();
    write_byte(8'h84, ak);
    check("R11 idle after abort, address acked", {7'd0, ak}, 8'h01);
    cpu_read(2'd3, r); check("R11 status after recovery", r, 8'h60);
    cpu_write(2'd2, 8'h04);
    bus_stop();
    wait_clk(4);
    cpu_read(2'd3, r); check("R7 stop at byte start", r, 8'hA0);
    cpu_write(2'd2, 8'h04);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule